// File: doc/BRIEF.md
# Host-to-DMA Word FIFO Bridge

The bridge sits between a 16-bit host write port and one DMA channel. The host first loads a transfer length, which also arms the bridge, and then pushes 16-bit words into a small circular buffer. Each time the buffered word count reaches a whole number of four-word groups, the bridge raises a request to the DMA side. When the DMA side acknowledges that request, the bridge drains the queue. It emits one word per clock on a write strobe, together with the current destination address. After each word the address advances by two.

The DMA channel is stood in for by a simple request/acknowledge handshake plus a loadable destination address and channel word count. Draining ends when the buffer runs dry or the channel count is used up. Any words that remain keep their order at the head of the buffer. The host can watch its remaining length, an armed flag, a full flag and the fill level. The armed flag drops by itself once the host length counts down to zero.

Top module: `wf_bridge`

## Requirements
- R1: A host write made while the armed flag `st_active` is 0 is dropped, and `st_fill` does not change.
- R2: A host write is accepted only while the fill, after any pop in the same cycle, is below the capacity of 8 words. `st_full` goes to 1 when the fill reaches 8. A write attempted at fill 8 with no drain running is dropped.
- R3: `dma_req` is 1 exactly when no drain is running, `chan_left` is nonzero, and `st_fill` is nonzero and a multiple of 4.
- R4: Each drained word appears for one cycle with `wr_valid`=1 and `wr_addr` equal to the current destination. The destination then grows by 2. `chan_left` and `st_len` each drop by 1 per word.
- R5: A drain, started by `dma_ack` while `dma_req` is 1, stops when the buffer is empty or `chan_left` is 0. Leftover words are drained later in their original order.
- R6: When a drain ends, `st_full` is 0 and `drain_busy` returns to 0 one cycle after the last word.
- R7: When `st_len` reaches 0 through draining, `st_active` becomes 0. `st_len` never goes below 0 while further words drain.
- R8: When a host write and a drain pop fall in the same cycle, the pop takes the head word and the write appends at the tail, so the fill is unchanged.
- R9: `len_load` loads `st_len` and sets `st_active` to 1 if the value is nonzero (0 otherwise). `chan_load` loads the destination and `chan_left` while no drain runs.
- R10: After reset the fill, length, armed flag, full flag, request and write strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_load | input | 1 | Load host length and arm |
| len_value | input | LEN_W (16) | Host transfer length in words |
| host_wr | input | 1 | Host word write strobe |
| host_data | input | DATA_W (16) | Host write data |
| chan_load | input | 1 | Load channel destination and count (ignored while draining) |
| chan_dest | input | ADDR_W (32) | Channel start destination address |
| chan_count | input | CNT_W (24) | Channel word count |
| dma_ack | input | 1 | DMA acknowledge, starts a drain when `dma_req` is 1 |
| dma_req | output | 1 | DMA request |
| wr_valid | output | 1 | Drained word strobe |
| wr_addr | output | ADDR_W (32) | Destination of the drained word |
| wr_data | output | DATA_W (16) | Drained word |
| st_len | output | LEN_W (16) | Remaining host length |
| st_active | output | 1 | Armed flag |
| st_full | output | 1 | Full flag |
| st_fill | output | FILL_W (4) | Words held |
| chan_left | output | CNT_W (24) | Remaining channel count |
| drain_busy | output | 1 | Drain in progress |

## Verification
A host write shows in `st_fill`, `st_full` and `dma_req` one clock after the edge that takes it. The first drained word appears one clock after the edge that samples `dma_ack`. Later words follow one per clock. `drain_busy` and `st_full` fall one clock after the last word. Inputs change on the falling edge and every output is compared on the falling edge after the rising edge that should update it, so each comparison lands on the cycle its result is due. A sweep over channel counts 1 to 8 on a full buffer computes the expected addresses, data order and leftover fill from a queue kept in the bench.

// File: rtl/wf_pkg.sv
package wf_pkg;

  localparam int GROUP_WORDS = 4;
  localparam int ADDR_STEP   = 2;

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_RUN  = 1'b1
  } drain_state_e;

  function automatic int fill_after(input int fill, input logic pop, input logic push);
    return fill - (pop ? 1 : 0) + (push ? 1 : 0);
  endfunction

  function automatic logic has_room(input int fill, input logic pop, input int depth);
    return (fill - (pop ? 1 : 0)) < depth;
  endfunction

  function automatic logic group_ready(input int fill, input int group);
    return (fill != 0) && ((fill % group) == 0);
  endfunction

endpackage

// File: rtl/wf_store.sv
module wf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [FILL_W-1:0] fill
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      if (push) wr_ptr <= step_ptr(wr_ptr);
      fill <= FILL_W'(wf_pkg::fill_after(int'(fill), pop, push));
    end
  end

  assign head = mem[rd_ptr];

  a_r2_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FILL_W'(DEPTH) && !pop) |=> fill == FILL_W'(DEPTH));

  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> fill != '0);

endmodule

// File: rtl/wf_track.sv
module wf_track #(
  parameter int LEN_W = 16,
  parameter int DEPTH = 8,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_load,
  input  logic [LEN_W-1:0]  len_value,
  input  logic              pop,
  input  logic              push,
  input  logic [FILL_W-1:0] fill_next,
  input  logic              drain_done,
  output logic [LEN_W-1:0]  len_q,
  output logic              active_q,
  output logic              full_q
);

  logic len_last;
  assign len_last = (len_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      active_q <= 1'b0;
    end else if (len_load) begin
      len_q    <= len_value;
      active_q <= (len_value != '0);
    end else if (pop && len_q != '0) begin
      len_q <= len_q - 1'b1;
      if (len_last) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else if (push && fill_next == FILL_W'(DEPTH)) full_q <= 1'b1;
    else if (drain_done) full_q <= 1'b0;
  end

  a_r7_active_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && len_last && !len_load) |=> !active_q);

  a_r4_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && len_q != '0 && !len_load) |=> len_q == $past(len_q) - 1'b1);

  a_r7_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0 && !len_load) |=> len_q == '0);

  a_r6_full_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_done && !push) |=> !full_q);

endmodule

// File: rtl/wf_drain.sv
module wf_drain #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DEPTH  = 8,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_load,
  input  logic [ADDR_W-1:0] chan_dest,
  input  logic [CNT_W-1:0]  chan_count,
  input  logic              dma_ack,
  input  logic [FILL_W-1:0] fill,
  output logic              dma_req,
  output logic              pop,
  output logic              drain_done,
  output logic              busy,
  output logic [ADDR_W-1:0] dest_q,
  output logic [CNT_W-1:0]  left_q
);

  wf_pkg::drain_state_e state_q;
  logic start;

  assign busy       = (state_q == wf_pkg::DR_RUN);
  assign pop        = busy && fill != '0 && left_q != '0;
  assign drain_done = busy && !pop;
  assign dma_req    = !busy && left_q != '0 &&
                      wf_pkg::group_ready(int'(fill), wf_pkg::GROUP_WORDS);
  assign start      = dma_req && dma_ack && !chan_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= wf_pkg::DR_IDLE;
      dest_q  <= '0;
      left_q  <= '0;
    end else if (!busy) begin
      if (chan_load) begin
        dest_q <= chan_dest;
        left_q <= chan_count;
      end else if (start) begin
        state_q <= wf_pkg::DR_RUN;
      end
    end else if (pop) begin
      dest_q <= dest_q + ADDR_W'(wf_pkg::ADDR_STEP);
      left_q <= left_q - 1'b1;
    end else begin
      state_q <= wf_pkg::DR_IDLE;
    end
  end

  a_r4_dest_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> dest_q == $past(dest_q) + ADDR_W'(wf_pkg::ADDR_STEP));

  a_r4_left_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> left_q == $past(left_q) - 1'b1);

  a_r5_stop_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0) |-> !pop);

  a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> !busy);

endmodule

// File: rtl/wf_bridge.sv
module wf_bridge #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 8,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_load,
  input  logic [LEN_W-1:0]  len_value,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              chan_load,
  input  logic [ADDR_W-1:0] chan_dest,
  input  logic [CNT_W-1:0]  chan_count,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LEN_W-1:0]  st_len,
  output logic              st_active,
  output logic              st_full,
  output logic [FILL_W-1:0] st_fill,
  output logic [CNT_W-1:0]  chan_left,
  output logic              drain_busy
);

  logic              pop, push, drain_done;
  logic [FILL_W-1:0] fill_next;

  assign push      = host_wr && st_active &&
                     wf_pkg::has_room(int'(st_fill), pop, DEPTH);
  assign fill_next = FILL_W'(wf_pkg::fill_after(int'(st_fill), pop, push));
  assign wr_valid  = pop;

  wf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .pop  (pop),
    .din  (host_data),
    .head (wr_data),
    .fill (st_fill)
  );

  wf_track #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_load  (len_load),
    .len_value (len_value),
    .pop       (pop),
    .push      (push),
    .fill_next (fill_next),
    .drain_done(drain_done),
    .len_q     (st_len),
    .active_q  (st_active),
    .full_q    (st_full)
  );

  wf_drain #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_load (chan_load),
    .chan_dest (chan_dest),
    .chan_count(chan_count),
    .dma_ack   (dma_ack),
    .fill      (st_fill),
    .dma_req   (dma_req),
    .pop       (pop),
    .drain_done(drain_done),
    .busy      (drain_busy),
    .dest_q    (wr_addr),
    .left_q    (chan_left)
  );

  a_r1_idle_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_active && !drain_busy) |=> st_fill == $past(st_fill));

  a_r8_swap_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push) |=> st_fill == $past(st_fill));

endmodule

// File: tb/sim_wf_bridge.sv
`timescale 1ns/1ps
module sim_wf_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_load = 1'b0;
  logic [15:0] len_value = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_data = '0;
  logic        chan_load = 1'b0;
  logic [31:0] chan_dest = '0;
  logic [23:0] chan_count = '0;
  logic        dma_ack = 1'b0;
  logic        dma_req, wr_valid, st_active, st_full, drain_busy;
  logic [31:0] wr_addr;
  logic [15:0] wr_data, st_len;
  logic [3:0]  st_fill;
  logic [23:0] chan_left;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [15:0] mq[$];
  int m_len = 0;
  bit m_active = 0;
  int m_dest = 0;
  int m_left = 0;
  int seed = 16'hA000;

  always #10 clk = ~clk;

  wf_bridge u0 (
    .clk(clk), .rst_n(rst_n), .len_load(len_load), .len_value(len_value),
    .host_wr(host_wr), .host_data(host_data), .chan_load(chan_load),
    .chan_dest(chan_dest), .chan_count(chan_count), .dma_ack(dma_ack),
    .dma_req(dma_req), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .st_len(st_len), .st_active(st_active), .st_full(st_full), .st_fill(st_fill),
    .chan_left(chan_left), .drain_busy(drain_busy)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic load_len(input int v);
    len_load = 1'b1; len_value = 16'(v);
    tick();
    len_load = 1'b0;
    m_len = v; m_active = (v != 0);
  endtask

  task automatic load_chan(input int d, input int c);
    chan_load = 1'b1; chan_dest = 32'(d); chan_count = 24'(c);
    tick();
    chan_load = 1'b0;
    m_dest = d; m_left = c;
  endtask

  task automatic host_write(output logic [15:0] v);
    v = 16'(seed);
    seed++;
    host_wr = 1'b1; host_data = v;
    tick();
    host_wr = 1'b0;
    if (m_active && mq.size() < 8) mq.push_back(v);
  endtask

  task automatic do_drain(input bit inject, input logic [15:0] extra);
    bit first = 1;
    chk("R3 req before ack", dma_req, 1);
    dma_ack = 1'b1;
    tick();
    dma_ack = 1'b0;
    while (mq.size() > 0 && m_left > 0) begin
      bit acc;
      acc = 0;
      chk("R4 wr_valid", wr_valid, 1);
      chk("R4 wr_addr", wr_addr, m_dest);
      chk("R5 wr_data order", wr_data, mq[0]);
      if (first && inject) begin
        host_wr = 1'b1; host_data = extra;
        acc = m_active;
      end
      void'(mq.pop_front());
      m_dest += 2; m_left--;
      if (m_len > 0) begin
        m_len--;
        if (m_len == 0) m_active = 0;
      end
      if (acc) mq.push_back(extra);
      tick();
      if (first && inject) begin
        host_wr = 1'b0;
        chk("R8 fill after pop and push", st_fill, mq.size());
      end
      first = 0;
    end
    chk("R5 drain stops", wr_valid, 0);
    tick();
    chk("R6 busy cleared", drain_busy, 0);
    chk("R6 full cleared", st_full, 0);
    chk("R5 leftover fill", st_fill, mq.size());
    chk("R4 chan_left", chan_left, m_left);
    chk("R4 st_len", st_len, m_len);
    chk("R7 st_active", st_active, m_active);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    @(negedge clk);
    chk("R10 reset fill", st_fill, 0);
    chk("R10 reset len", st_len, 0);
    chk("R10 reset active", st_active, 0);
    chk("R10 reset full", st_full, 0);
    chk("R10 reset req", dma_req, 0);
    chk("R10 reset wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    tick();

    // R1: writes while unarmed are dropped
    for (int i = 0; i < 3; i++) begin
      host_write(v);
      chk("R1 unarmed write dropped", st_fill, 0);
    end

    // R9: a zero length leaves the bridge unarmed
    load_len(0);
    chk("R9 zero length unarmed", st_active, 0);
    load_len(40);
    chk("R9 len loaded", st_len, 40);
    chk("R9 armed", st_active, 1);
    load_chan(32'h100, 6);
    chk("R9 chan_left loaded", chan_left, 6);
    chk("R9 dest loaded", wr_addr, 32'h100);

    // R2/R3: fill up, request only on groups of four
    for (int i = 1; i <= 8; i++) begin
      host_write(v);
      chk("R2 fill count", st_fill, i);
      chk("R3 req on group", dma_req, (i % 4 == 0));
      chk("R2 full flag", st_full, (i == 8));
    end
    host_write(v);
    chk("R2 write at capacity dropped", st_fill, 8);
    chk("R2 full stays", st_full, 1);

    // R5: channel count ends the drain early
    do_drain(0, '0);
    chk("R3 no req with count zero", dma_req, 0);

    // R8: write in the same cycle as a pop
    load_chan(32'h200, 20);
    host_write(v);
    host_write(v);
    chk("R3 req at four", dma_req, 1);
    do_drain(1, 16'hBEEF);
    chk("R5 emptied", st_fill, 0);

    // sweep of channel counts on a full buffer
    load_len(200);
    for (int c = 1; c <= 8; c++) begin
      load_chan(32'h1000 + 32'h100 * c, c);
      while (mq.size() < 8) host_write(v);
      chk("R3 req when refilled", dma_req, 1);
      chk("R2 full when refilled", st_full, 1);
      do_drain(0, '0);
      chk("R5 sweep leftover", st_fill, 8 - c);
    end

    // R7: length runs out during a drain
    load_len(3);
    load_chan(32'h300, 10);
    for (int i = 0; i < 4; i++) host_write(v);
    do_drain(0, '0);
    chk("R7 length floor", st_len, 0);
    chk("R7 unarmed at zero", st_active, 0);
    host_write(v);
    chk("R1 write after length end dropped", st_fill, 0);

    finish_run();
  end

endmodule